// File: doc/BRIEF.md
# Accumulator Machine Fetch and Address Sequencer

This block is the timing controller for a small accumulator machine with 16-bit instruction words and a 4096-word memory space. It steps through a fixed schedule of register transfers. In the first step the memory address register takes the program counter and a read starts at that address. In the second step the returned word goes into the instruction register and the program counter advances. In the third step the opcode is decoded into eight one-hot lines, the 12-bit address field goes into the address register, and the indirect bit is latched.

When the indirect bit is set, two further steps follow. The first issues a memory read at the address register. The second replaces the address register with the low 12 bits of the returned word, which is the effective address. A stub execute phase then runs for a parameterised number of cycles, and the schedule restarts at the first step. Memory has a synchronous read port: a read that is requested in one cycle returns its data in the following cycle.

The instruction word layout is as follows. Bit 15 is the indirect flag. Bits 14..12 hold the opcode. Bits 11..0 hold the address.

Top module: `acc_fetch_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the PC, the address register, the instruction register, the indirect flag and all decode lines to zero, and returns the schedule to its first step. While `rst` is high, `fetch_start` and `mem_rd` stay low.
- R2: In the first step, `mem_rd` is high and `mem_addr` equals the PC. At the end of this step the address register takes the PC value.
- R3: In the second step the instruction register takes `mem_rdata`, and the PC increments by one modulo 4096, so 4095 wraps to 0. In every other step the PC holds its value.
- R4: At the end of the third step, exactly one decode line is high: line k, where k is instruction bits 14..12. The decode lines keep that value until the next third step.
- R5: At the end of the third step, the address register takes instruction bits 11..0 and the indirect flag takes instruction bit 15.
- R6: When bit 15 is 1, the third step is followed by a read step and then a load step. In the read step, `mem_rd` is high and `mem_addr` equals the address register. In the load step, the address register takes `mem_rdata[11:0]`. When bit 15 is 0, the schedule goes straight from the third step to execute.
- R7: The execute phase lasts `EXEC_CYCLES` cycles (default 2), with `exec_busy` high during it. The cycle after it ends is a first step.
- R8: `fetch_start` is high for exactly the single cycle of each first step.
- R9: `mem_rd` is high only in the first step and in the indirect read step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_rdata | input | 16 | Word returned by memory one cycle after a read request |
| mem_addr | output | 12 | Memory read address |
| mem_rd | output | 1 | Memory read request |
| pc | output | 12 | Program counter |
| ar | output | 12 | Memory address register |
| ir | output | 16 | Instruction register |
| ind | output | 1 | Latched indirect flag |
| dec | output | 8 | One-hot opcode decode lines |
| fetch_start | output | 1 | Pulse marking the first step of each instruction |
| exec_busy | output | 1 | High during the stub execute phase |

## Verification
A wrong timing step shows up at once at the ports. `fetch_start`, `mem_rd` or `exec_busy` appears in the wrong cycle, and the instruction period moves away from 3+E cycles for a direct instruction or 5+E cycles for an indirect one. A corrupted PC or address register shows up in `mem_addr` at the next read request, which is at most a few cycles later. From then on every fetched word differs from the reference model, so a single slip spreads to `ir` and `dec` within one instruction. The PC wrap from 4095 to 0, both paths of the indirect branch, and all eight decode lines are each exercised.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;
  // Timing steps of the sequencer
  typedef enum logic [2:0] {
    ST_T0  = 3'd0,  // address register <- PC, read request
    ST_T1  = 3'd1,  // IR <- memory word, PC + 1
    ST_T2  = 3'd2,  // decode, address field, indirect flag
    ST_IRD = 3'd3,  // indirect: read request at address register
    ST_IWB = 3'd4,  // indirect: address register <- effective address
    ST_EXE = 3'd5   // stub execute
  } step_e;
endpackage

// File: rtl/seq_timer.sv
module seq_timer
  import acc_seq_pkg::*;
#(
  parameter int EXEC_CYCLES = 2
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  ind_bit,
  output step_e step,
  output logic  exe_last
);
  localparam int CW = (EXEC_CYCLES > 1) ? $clog2(EXEC_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(EXEC_CYCLES - 1);

  logic [CW-1:0] cnt;

  assign exe_last = (step == ST_EXE) && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      step <= ST_T0;
      cnt  <= '0;
    end else begin
      case (step)
        ST_T0:   step <= ST_T1;
        ST_T1:   step <= ST_T2;
        ST_T2: begin
          step <= ind_bit ? ST_IRD : ST_EXE;
          cnt  <= '0;
        end
        ST_IRD:  step <= ST_IWB;
        ST_IWB: begin
          step <= ST_EXE;
          cnt  <= '0;
        end
        ST_EXE: begin
          if (exe_last) step <= ST_T0;
          else          cnt  <= cnt + 1'b1;
        end
        default: step <= ST_T0;
      endcase
    end
  end

  p_t0_to_t1_r2: assert property (@(posedge clk) disable iff (rst)
    step == ST_T0 |=> step == ST_T1);
  p_ind_branch_r6: assert property (@(posedge clk) disable iff (rst)
    (step == ST_T2 && ind_bit) |=> step == ST_IRD);
  p_direct_skip_r6: assert property (@(posedge clk) disable iff (rst)
    (step == ST_T2 && !ind_bit) |=> step == ST_EXE);
  p_exec_return_r7: assert property (@(posedge clk) disable iff (rst)
    exe_last |=> step == ST_T0);
endmodule

// File: rtl/fetch_regs.sv
module fetch_regs
  import acc_seq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  step_e             step,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] ar,
  output logic [DATA_W-1:0] ir,
  output logic              ind
);
  function automatic logic [ADDR_W-1:0] pc_next(input logic [ADDR_W-1:0] p);
    return ADDR_W'(p + 1'b1);
  endfunction

  function automatic logic [ADDR_W-1:0] addr_field(input logic [DATA_W-1:0] w);
    return w[ADDR_W-1:0];
  endfunction

  function automatic logic ind_field(input logic [DATA_W-1:0] w);
    return w[DATA_W-1];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= '0;
      ar  <= '0;
      ir  <= '0;
      ind <= 1'b0;
    end else begin
      case (step)
        ST_T0: ar <= pc;
        ST_T1: begin
          ir <= mem_rdata;
          pc <= pc_next(pc);
        end
        ST_T2: begin
          ar  <= addr_field(ir);
          ind <= ind_field(ir);
        end
        ST_IWB: ar <= addr_field(mem_rdata);
        default: ;
      endcase
    end
  end

  p_pc_inc_r3: assert property (@(posedge clk) disable iff (rst)
    step == ST_T1 |=> pc == ADDR_W'($past(pc) + 1'b1));
  p_pc_hold_r3: assert property (@(posedge clk) disable iff (rst)
    step != ST_T1 |=> $stable(pc));
  p_ar_load_r2: assert property (@(posedge clk) disable iff (rst)
    step == ST_T0 |=> ar == $past(pc));
  p_ar_field_r5: assert property (@(posedge clk) disable iff (rst)
    step == ST_T2 |=> (ar == $past(ir[ADDR_W-1:0]) && ind == $past(ir[DATA_W-1])));
endmodule

// File: rtl/op_decoder.sv
module op_decoder #(
  parameter int OPC_W = 3,
  localparam int NLINES = 1 << OPC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [OPC_W-1:0]  opc,
  output logic [NLINES-1:0] dec
);
  logic [NLINES-1:0] dec_n;

  for (genvar k = 0; k < NLINES; k++) begin : g_line
    assign dec_n[k] = (opc == OPC_W'(k));
  end

  always_ff @(posedge clk) begin
    if (rst)       dec <= '0;
    else if (load) dec <= dec_n;
  end

  p_dec_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    load |=> $countones(dec) == 1);
  p_dec_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(dec));
endmodule

// File: rtl/acc_fetch_seq.sv
module acc_fetch_seq
  import acc_seq_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 12,
  parameter int OPC_W       = 3,
  parameter int EXEC_CYCLES = 2,
  localparam int NLINES     = 1 << OPC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] ar,
  output logic [DATA_W-1:0] ir,
  output logic              ind,
  output logic [NLINES-1:0] dec,
  output logic              fetch_start,
  output logic              exec_busy
);
  step_e step;
  logic  exe_last;
  logic  in_t0, in_ird;

  seq_timer #(.EXEC_CYCLES(EXEC_CYCLES)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .ind_bit  (ir[DATA_W-1]),
    .step     (step),
    .exe_last (exe_last)
  );

  fetch_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .step      (step),
    .mem_rdata (mem_rdata),
    .pc        (pc),
    .ar        (ar),
    .ir        (ir),
    .ind       (ind)
  );

  op_decoder #(.OPC_W(OPC_W)) u_dec (
    .clk  (clk),
    .rst  (rst),
    .load (step == ST_T2),
    .opc  (ir[DATA_W-2 -: OPC_W]),
    .dec  (dec)
  );

  assign in_t0       = (step == ST_T0) && !rst;
  assign in_ird      = (step == ST_IRD) && !rst;
  assign fetch_start = in_t0;
  assign mem_rd      = in_t0 || in_ird;
  assign mem_addr    = in_t0 ? pc : ar;
  assign exec_busy   = (step == ST_EXE) && !rst;

  p_fetch_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    fetch_start |=> !fetch_start);
  p_rd_source_r9: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> (fetch_start || step == ST_IRD));
  p_exec_then_fetch_r7: assert property (@(posedge clk) disable iff (rst)
    (exec_busy && exe_last) |=> fetch_start);
endmodule

// File: tb/test_acc_fetch_seq.sv
module test_acc_fetch_seq;
  localparam int CLK_P = 10;
  localparam int EXC   = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] mem_rdata = '0;
  logic [11:0] mem_addr, pc, ar;
  logic        mem_rd, ind, fetch_start, exec_busy;
  logic [15:0] ir;
  logic [7:0]  dec;

  int n_chk = 0, n_fail = 0;

  acc_fetch_seq #(.EXEC_CYCLES(EXC)) i_acc_fetch_seq (
    .clk(clk), .rst(rst), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .pc(pc), .ar(ar), .ir(ir), .ind(ind), .dec(dec),
    .fetch_start(fetch_start), .exec_busy(exec_busy)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [15:0] mem_word(input logic [11:0] a);
    int v;
    v = (int'(a) * 40503) ^ (int'(a) >> 3) ^ 32'h5A3C;
    return v[15:0];
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= mem_word(mem_addr);

  // Behavioural reference: step 0..5 = fetch, load IR, decode, ind read, ind load, exec
  int          m_step = 0, m_cnt = 0;
  logic [11:0] m_pc = '0, m_ar = '0;
  logic [15:0] m_ir = '0;
  logic        m_ind = 1'b0;
  logic [7:0]  m_dec = '0;

  always @(posedge clk) begin
    if (rst) begin
      m_step <= 0; m_cnt <= 0; m_pc <= '0; m_ar <= '0;
      m_ir <= '0; m_ind <= 1'b0; m_dec <= '0;
    end else begin
      case (m_step)
        0: begin m_ar <= m_pc; m_step <= 1; end
        1: begin m_ir <= mem_word(m_ar); m_pc <= m_pc + 12'd1; m_step <= 2; end
        2: begin
          m_dec  <= 8'd1 << m_ir[14:12];
          m_ar   <= m_ir[11:0];
          m_ind  <= m_ir[15];
          m_cnt  <= 0;
          m_step <= m_ir[15] ? 3 : 5;
        end
        3: m_step <= 4;
        4: begin m_ar <= mem_word(m_ar)[11:0]; m_step <= 5; end
        default: begin
          if (m_cnt == EXC - 1) m_step <= 0;
          else m_cnt <= m_cnt + 1;
        end
      endcase
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  int  since_fetch = 0;
  bit  saw_ind = 0, saw_dir = 0, saw_wrap = 0;
  logic [7:0] seen_lines = '0;
  logic [11:0] prev_pc = '0;

  always @(negedge clk) begin
    logic e_fs, e_rd, e_busy;
    e_fs   = !rst && m_step == 0;
    e_rd   = !rst && (m_step == 0 || m_step == 3);
    e_busy = !rst && m_step == 5;
    chk(pc == m_pc,   rst ? "R1 pc" : "R3 pc", 32'(pc), 32'(m_pc));
    chk(ar == m_ar,   rst ? "R1 ar" : "R2 R5 R6 ar", 32'(ar), 32'(m_ar));
    chk(ir == m_ir,   rst ? "R1 ir" : "R3 ir", 32'(ir), 32'(m_ir));
    chk(ind == m_ind, rst ? "R1 ind" : "R5 ind", 32'(ind), 32'(m_ind));
    chk(dec == m_dec, rst ? "R1 dec" : "R4 dec", 32'(dec), 32'(m_dec));
    chk(fetch_start == e_fs, "R8 fetch_start", 32'(fetch_start), 32'(e_fs));
    chk(mem_rd == e_rd, "R9 mem_rd", 32'(mem_rd), 32'(e_rd));
    chk(exec_busy == e_busy, "R7 exec_busy", 32'(exec_busy), 32'(e_busy));
    if (e_rd)
      chk(mem_addr == (m_step == 0 ? m_pc : m_ar), "R2 R6 mem_addr",
          32'(mem_addr), 32'(m_step == 0 ? m_pc : m_ar));
    if (!rst) begin
      if (m_step == 3) saw_ind = 1;
      if (m_step == 5 && m_cnt == 0 && !m_ind) saw_dir = 1;
      if (prev_pc == 12'hFFF && pc == 12'h000) saw_wrap = 1;
      seen_lines = seen_lines | dec;
      since_fetch = fetch_start ? 0 : since_fetch + 1;
      if (since_fetch > 100) begin
        n_fail++;
        $display("FAIL watchdog R8 actual=%0d expected=<=%0d", since_fetch, 5 + EXC);
        finish_run();
      end
    end else since_fetch = 0;
    prev_pc = pc;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (28000) @(negedge clk);
    rst = 1'b1;                      // R1: mid-run reset
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (3000) @(negedge clk);
    chk(saw_ind, "R6 indirect path seen", 32'(saw_ind), 1);
    chk(saw_dir, "R6 direct path seen", 32'(saw_dir), 1);
    chk(saw_wrap, "R3 PC wrap seen", 32'(saw_wrap), 1);
    for (int k = 0; k < 8; k++)
      chk(seen_lines[k], "R4 decode line seen", 32'(seen_lines[k]), 1);
    finish_run();
  end
endmodule